// File: doc/BRIEF.md
# Timeslot PRBS Bit-Error Tester

This block is a bit-error test engine for a time-division-multiplexed serial fabric. A frame holds a fixed number of 8-bit channels. Every stream carries these channels in parallel, one bit per bit-time strobe. On the transmit side the block places a 2^15-1 pseudo-random sequence into one chosen channel of one chosen output stream. Every other output bit stays idle high.

On the receive side the block takes the bits of one chosen channel of one chosen input stream. It loads them into a reference history until the history is full, then predicts each following bit from that history and counts each bit that disagrees. The count is held in a saturating register. If errors persist slot after slot, the receiver gives up its lock, raises a sticky loss-of-sync flag and hunts again.

Software picks the transmit slot, the receive slot and the clear action through a small register port. The transmit and receive selections are independent, so one engine can test a looped path or two unrelated paths.

Top module: `tdm_bert`

## Requirements
- R1: After a synchronous reset every `ser_out` bit is 1 and all four registers read 0, so transmit and receive are both disabled.
- R2: A `bit_tick` cycle with `frame_sync` high is bit 0 of channel 0. Each channel spans 8 consecutive ticks, and the position advances only on ticks. It wraps after N_CHANS*8 ticks, and `frame_sync` restarts it from any position.
- R3: On each tick, the selected output stream takes the next pattern bit while the transmit channel is current. All other stream bits, and every bit while transmit is disabled, take 1. `ser_out` is registered and changes only on ticks.
- R4: The pattern obeys x^15+x^14+1, so bit n+15 = bit n XOR bit n+1. The generator state is all ones after reset, so the first 15 pattern bits are 1. The generator advances only on ticks inside the selected transmit slot.
- R5: Register map (`cfg_addr`). Address 0 selects transmit and address 1 selects receive. In both, bits [7:0] are the channel, [12:8] the stream and bit 15 the enable, and the whole 16-bit word reads back as written. A write to address 2 with bit 0 set clears. A read of address 2 returns {los, locked} in bits [1:0]. Address 3 reads the error count. `cfg_rdata` is registered and shows the addressed register one cycle after `cfg_addr`.
- R6: While hunting, the receiver loads received slot bits and counts nothing. After the 15th loaded bit it is locked.
- R7: When locked, each received bit is compared with the XOR of the bits received 15 and 14 positions earlier, and each disagreement adds 1 to the count.
- R8: The error count stops at all ones (255 with ERR_W=8).
- R9: A clear write sets the error count and the loss-of-sync flag to 0.
- R10: When locked, 8 consecutive receive slots each holding at least one error drop the lock and set the sticky loss-of-sync flag. The receiver then hunts again.
- R11: A write to the receive select register restarts the hunt without changing the count. A disabled receiver ignores its input, and count and lock stay unchanged.
- R12: Writing the transmit select register has no effect on the receiver's lock or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_sync | input | 1 | Marks the tick that is bit 0 of channel 0 |
| ser_in | input | N_STREAMS | Serial input bit of every stream |
| ser_out | output | N_STREAMS | Serial output bit of every stream |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data |

## Verification
The hardest state to reach is a saturated error count with the receiver still locked. Bit errors that come in a dense burst trip the loss-of-sync rule long before the count fills. To get there, the bench flips one received bit in every third frame. Each flipped bit costs three mispredictions spread over two slots, so the run of errored slots never reaches eight while the count climbs past its limit. The bench shrinks the frame to four channels and the counter to 8 bits so this takes a few hundred frames. A fully inverted input drives the opposite corner, a repeated loss and re-hunt cycle. A truncated frame followed by `frame_sync` checks realignment.

// File: rtl/tdm_bert_pkg.sv
package tdm_bert_pkg;

  localparam int PRBS_W    = 15;
  localparam int SLOT_BITS = 8;

  typedef enum logic [1:0] {
    REG_TXSEL  = 2'd0,
    REG_RXSEL  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_ERRCNT = 2'd3
  } reg_addr_e;

  // One step of the x^15 + x^14 + 1 generator; bit 14 is the output bit.
  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction

endpackage

// File: rtl/tdm_bert_timing.sv
module tdm_bert_timing
  import tdm_bert_pkg::*;
#(
  parameter int N_CHANS = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_tick,
  input  logic                       frame_sync,
  output logic [$clog2(N_CHANS)-1:0] chan,
  output logic                       slot_last
);

  localparam int FRAME_BITS = N_CHANS * SLOT_BITS;
  localparam int FB_W       = $clog2(FRAME_BITS);
  localparam logic [FB_W-1:0] LAST_POS = FB_W'(FRAME_BITS - 1);

  logic [FB_W-1:0] pos;
  logic [FB_W-1:0] cur;

  // Position of the bit being presented in this cycle.
  assign cur       = frame_sync ? '0 : pos;
  assign chan      = cur[FB_W-1:3];
  assign slot_last = &cur[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (bit_tick) begin
      pos <= (cur == LAST_POS) ? '0 : cur + 1'b1;
    end
  end

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && frame_sync) |=> (pos == FB_W'(1))); // R2
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(pos)); // R2

endmodule

// File: rtl/tdm_bert_tx.sv
module tdm_bert_tx
  import tdm_bert_pkg::*;
#(
  parameter int N_STREAMS = 32,
  parameter int N_CHANS   = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bit_tick,
  input  logic [$clog2(N_CHANS)-1:0]   chan,
  input  logic                         sel_en,
  input  logic [$clog2(N_STREAMS)-1:0] sel_st,
  input  logic [$clog2(N_CHANS)-1:0]   sel_ch,
  output logic [N_STREAMS-1:0]         ser_out
);

  localparam int ST_W = $clog2(N_STREAMS);

  logic [PRBS_W-1:0]    lfsr;
  logic                 hit;
  logic [N_STREAMS-1:0] lane_nxt;

  assign hit = sel_en && (sel_ch == chan);

  // Lane multiplexer: only the selected stream carries the pattern bit.
  for (genvar g = 0; g < N_STREAMS; g++) begin : g_lane
    assign lane_nxt[g] = (hit && (sel_st == ST_W'(g))) ? lfsr[PRBS_W-1] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= '1;
      ser_out <= '1;
    end else if (bit_tick) begin
      ser_out <= lane_nxt;
      if (hit) lfsr <= prbs_step(lfsr);
    end
  end

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ser_out) <= 1); // R3
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !sel_en) |=> (&ser_out)); // R3
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bit_tick && hit) |=> $stable(lfsr)); // R4
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0); // R4

endmodule

// File: rtl/tdm_bert_rx.sv
module tdm_bert_rx
  import tdm_bert_pkg::*;
#(
  parameter int N_STREAMS = 32,
  parameter int ERR_W     = 16,
  parameter int LOS_SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bit_tick,
  input  logic                         hit,
  input  logic                         slot_last,
  input  logic [N_STREAMS-1:0]         ser_in,
  input  logic [$clog2(N_STREAMS)-1:0] sel_st,
  input  logic                         restart,
  input  logic                         clear,
  output logic                         locked,
  output logic                         los,
  output logic [ERR_W-1:0]             err_cnt
);

  localparam int BAD_W  = $clog2(LOS_SLOTS + 1);
  localparam int FILL_W = $clog2(PRBS_W + 1);

  logic [PRBS_W-1:0] hist;
  logic [FILL_W-1:0] fill;
  logic [BAD_W-1:0]  bad;
  logic              slot_err;
  logic              rx_bit;
  logic              sample;
  logic              mis;
  logic              slot_bad;

  assign rx_bit   = ser_in[sel_st];
  assign sample   = bit_tick && hit;
  assign mis      = locked && sample && (rx_bit ^ hist[PRBS_W-1] ^ hist[PRBS_W-2]);
  assign slot_bad = slot_err | mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      fill     <= '0;
      bad      <= '0;
      slot_err <= 1'b0;
      locked   <= 1'b0;
      los      <= 1'b0;
      err_cnt  <= '0;
    end else begin
      if (clear) begin
        err_cnt <= '0;
        los     <= 1'b0;
      end else if (mis && !(&err_cnt)) begin
        err_cnt <= err_cnt + 1'b1;
      end

      if (restart) begin
        locked   <= 1'b0;
        fill     <= '0;
        bad      <= '0;
        slot_err <= 1'b0;
      end else if (sample) begin
        hist <= {hist[PRBS_W-2:0], rx_bit};
        if (!locked) begin
          if (fill == FILL_W'(PRBS_W - 1)) begin
            locked <= 1'b1;
            fill   <= '0;
          end else begin
            fill <= fill + 1'b1;
          end
        end else if (slot_last) begin
          slot_err <= 1'b0;
          if (slot_bad) begin
            if (bad == BAD_W'(LOS_SLOTS - 1)) begin
              locked <= 1'b0;
              los    <= 1'b1;
              bad    <= '0;
            end else begin
              bad <= bad + 1'b1;
            end
          end else begin
            bad <= '0;
          end
        end else begin
          slot_err <= slot_bad;
        end
      end
    end
  end

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    ((&err_cnt) && !clear) |=> (&err_cnt)); // R8
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1)); // R7
  AST_HUNT_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!locked && !clear) |=> $stable(err_cnt)); // R6
  AST_LOS_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> $past(locked)); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (err_cnt == '0)); // R9

endmodule

// File: rtl/tdm_bert.sv
module tdm_bert
  import tdm_bert_pkg::*;
#(
  parameter int N_STREAMS = 32,
  parameter int N_CHANS   = 256,
  parameter int ERR_W     = 16,
  parameter int LOS_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 frame_sync,
  input  logic [N_STREAMS-1:0] ser_in,
  output logic [N_STREAMS-1:0] ser_out,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [15:0]          cfg_wdata,
  output logic [15:0]          cfg_rdata
);

  localparam int ST_W = $clog2(N_STREAMS);
  localparam int CH_W = $clog2(N_CHANS);

  logic [15:0]      tx_word;
  logic [15:0]      rx_word;
  logic [CH_W-1:0]  chan;
  logic             slot_last;
  logic             rx_hit;
  logic             restart;
  logic             clear;
  logic             locked;
  logic             los;
  logic [ERR_W-1:0] err_cnt;

  assign restart = cfg_we && (cfg_addr == REG_RXSEL);
  assign clear   = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0];
  assign rx_hit  = rx_word[15] && (rx_word[0 +: CH_W] == chan);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word <= '0;
      rx_word <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == REG_TXSEL) tx_word <= cfg_wdata;
      if (cfg_addr == REG_RXSEL) rx_word <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (reg_addr_e'(cfg_addr))
        REG_TXSEL:  cfg_rdata <= tx_word;
        REG_RXSEL:  cfg_rdata <= rx_word;
        REG_CTRL:   cfg_rdata <= {14'd0, los, locked};
        default:    cfg_rdata <= 16'(err_cnt);
      endcase
    end
  end

  tdm_bert_timing #(
    .N_CHANS (N_CHANS)
  ) u_timing (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .frame_sync (frame_sync),
    .chan       (chan),
    .slot_last  (slot_last)
  );

  tdm_bert_tx #(
    .N_STREAMS (N_STREAMS),
    .N_CHANS   (N_CHANS)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .chan     (chan),
    .sel_en   (tx_word[15]),
    .sel_st   (tx_word[8 +: ST_W]),
    .sel_ch   (tx_word[0 +: CH_W]),
    .ser_out  (ser_out)
  );

  tdm_bert_rx #(
    .N_STREAMS (N_STREAMS),
    .ERR_W     (ERR_W),
    .LOS_SLOTS (LOS_SLOTS)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .hit       (rx_hit),
    .slot_last (slot_last),
    .ser_in    (ser_in),
    .sel_st    (rx_word[8 +: ST_W]),
    .restart   (restart),
    .clear     (clear),
    .locked    (locked),
    .los       (los),
    .err_cnt   (err_cnt)
  );

  AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    restart |=> !locked); // R11
  AST_RESTART_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (restart && !clear) |=> $stable(err_cnt)); // R11

endmodule

// File: tb/tdm_bert_tb.sv
module tdm_bert_tb;

  localparam int NS = 4;
  localparam int NC = 4;
  localparam int EW = 8;
  localparam int FB = NC * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_tick = 1'b0;
  logic          frame_sync = 1'b0;
  logic [NS-1:0] ser_in = '0;
  logic [NS-1:0] ser_out;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;

  always #5 clk = ~clk;

  tdm_bert #(.N_STREAMS(NS), .N_CHANS(NC), .ERR_W(EW), .LOS_SLOTS(8)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_sync(frame_sync),
    .ser_in(ser_in), .ser_out(ser_out), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state derived from the requirements
  logic [14:0] t_s;
  logic [14:0] g_s = 15'h2A5B;
  logic [14:0] m_h;
  int  m_fill, m_bad, m_err, frame_no;
  bit  m_lock, m_los, m_slot;
  bit  t_en, r_en;
  int  t_ch, t_st, r_ch, r_st;

  // Vector: [1:0] tx ch, [3:2] tx st, [5:4] rx ch, [7:6] rx st,
  // [15:8] frames, [17:16] error kind, [18] clear first, [19] write rx select
  localparam logic [19:0] VEC [5] = '{
    {1'b1, 1'b0, 2'd0, 8'd4, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 1'b0, 2'd1, 8'd6, 2'd0, 2'd3, 2'd3, 2'd0},
    {1'b1, 1'b1, 2'd0, 8'd5, 2'd1, 2'd0, 2'd0, 2'd3},
    {1'b0, 1'b0, 2'd2, 8'd8, 2'd1, 2'd0, 2'd0, 2'd3},
    {1'b0, 1'b1, 2'd0, 8'd5, 2'd1, 2'd0, 2'd1, 2'd2}
  };

  function automatic logic [14:0] nxt(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    t_s = '1; m_h = '0; m_fill = 0; m_bad = 0; m_err = 0;
    m_lock = 0; m_los = 0; m_slot = 0;
    t_en = 0; r_en = 0; t_ch = 0; t_st = 0; r_ch = 0; r_st = 0;
  endtask

  task automatic cfg_write(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) begin t_en = d[15]; t_st = int'(d[9:8]); t_ch = int'(d[1:0]); end
    if (a == 1) begin
      r_en = d[15]; r_st = int'(d[9:8]); r_ch = int'(d[1:0]);
      m_lock = 0; m_fill = 0; m_bad = 0; m_slot = 0;
    end
    if (a == 2 && d[0]) begin m_err = 0; m_los = 0; end
  endtask

  task automatic cfg_read(input int a, output int v);
    @(negedge clk);
    cfg_addr = 2'(a);
    @(negedge clk);
    v = int'(cfg_rdata);
  endtask

  task automatic m_rx(input bit b, input bit last);
    bit mis;
    if (!m_lock) begin
      m_h = {m_h[13:0], b};
      if (m_fill == 14) begin m_lock = 1; m_fill = 0; end
      else m_fill++;
    end else begin
      mis = b ^ m_h[14] ^ m_h[13];
      m_h = {m_h[13:0], b};
      if (mis && m_err < (1 << EW) - 1) m_err++;
      if (last) begin
        if (m_slot || mis) begin
          if (m_bad == 7) begin m_lock = 0; m_los = 1; m_bad = 0; end
          else m_bad++;
        end else m_bad = 0;
        m_slot = 0;
      end else m_slot = m_slot | mis;
    end
  endtask

  // kind 0 clean, 1 flip bit 0 of the slot every third frame, 2 invert all
  task automatic run_frames(input int n, input int kind, input int len);
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < len; i++) begin
        bit txs, rxs, b, e;
        int ch;
        ch = i / 8;
        @(negedge clk);
        bit_tick = 1'b1;
        frame_sync = (i == 0);
        ser_in = (i % 2 == 1) ? '1 : '0;
        rxs = r_en && (ch == r_ch);
        b = 1'b0;
        if (rxs) begin
          b = g_s[14];
          g_s = nxt(g_s);
          if (kind == 2) b = ~b;
          else if (kind == 1 && frame_no % 3 == 0 && i % 8 == 0) b = ~b;
          ser_in[r_st] = b;
        end
        @(negedge clk);
        bit_tick = 1'b0;
        frame_sync = 1'b0;
        txs = t_en && (ch == t_ch);
        for (int s = 0; s < NS; s++) begin
          e = (txs && s == t_st) ? t_s[14] : 1'b1;
          chk("R2 R3 R4 lane", int'(ser_out[s]), int'(e));
        end
        if (txs) t_s = nxt(t_s);
        if (rxs) m_rx(b, (i % 8) == 7);
      end
      frame_no++;
    end
  endtask

  task automatic check_rx(input string tag);
    int v;
    cfg_read(2, v);
    chk({tag, " R6 R10 status"}, v, (int'(m_los) << 1) | int'(m_lock));
    cfg_read(3, v);
    chk({tag, " R7 count"}, v, m_err);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, cnt_before;
    frame_no = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 ser_out idle", int'(ser_out), (1 << NS) - 1);
    for (int a = 0; a < 4; a++) begin
      cfg_read(a, v);
      chk("R1 register reset", v, 0);
    end

    // R5: select word reads back whole
    cfg_write(0, 16'hE201);
    cfg_read(0, v);
    chk("R5 tx readback", v, 16'hE201);
    cfg_write(1, 16'h6103);
    cfg_read(1, v);
    chk("R5 rx readback", v, 16'h6103);

    // Table walk
    for (int k = 0; k < 5; k++) begin
      logic [19:0] w;
      w = VEC[k];
      if (w[18]) cfg_write(2, 16'h0001);
      cfg_write(0, 16'h8000 | (16'(w[3:2]) << 8) | 16'(w[1:0]));
      if (w[19]) cfg_write(1, 16'h8000 | (16'(w[7:6]) << 8) | 16'(w[5:4]));
      run_frames(int'(w[15:8]), int'(w[17:16]), FB);
      check_rx("R12");
    end

    // R9: clear zeroes count and loss flag
    cfg_write(2, 16'h0001);
    cfg_read(3, v);
    chk("R9 count cleared", v, 0);
    cfg_read(2, v);
    chk("R9 los cleared", v & 2, 0);

    // R2: truncated frame, then realign on frame_sync
    cfg_write(0, 16'h8101);
    run_frames(1, 0, 13);
    run_frames(2, 0, FB);

    // R8: sparse errors drive the count to saturation while locked
    cfg_write(1, 16'h8102);
    run_frames(300, 1, FB);
    cfg_read(3, v);
    chk("R8 saturated count", v, 255);
    check_rx("R8");

    // R11: restart keeps count; disabled receiver ignores input
    cnt_before = m_err;
    cfg_write(1, 16'h0102);
    run_frames(2, 2, FB);
    cfg_read(3, v);
    chk("R11 count unchanged", v, cnt_before);
    cfg_read(2, v);
    chk("R11 not locked", v & 1, 0);

    // R3: transmit disabled gives idle lanes
    cfg_write(0, 16'h0000);
    run_frames(1, 0, FB);

    // R1 R4: mid-run reset reseeds the generator
    cfg_write(0, 16'h8000);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 ser_out after reset", int'(ser_out), (1 << NS) - 1);
    cfg_read(0, v);
    chk("R1 tx select after reset", v, 0);
    cfg_write(0, 16'h8300);
    run_frames(3, 0, FB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule